// File: doc/BRIEF.md
# Self-Timed Array Programming Engine with Supply Lockout

This block sits behind a serial command front end and carries out programming requests against a small register-file storage array. It handles four request kinds: a write of one to sixteen bytes inside one sixteen-byte page, an erase of one location, an erase of the whole array, and a fill of the whole array with one byte value. The front end hands over a completed request with a one-cycle `reqValid` pulse, which it raises when chip select is released. From then on the engine times the cycle by itself and needs no further serial clocks. While a cycle runs, `busy` is high so that status polling can report ready or busy.

A supply-lockout controller watches a digital "supply above trip" signal from an external comparator. Lockout goes active in the same cycle that the supply goes low. After the supply recovers, lockout is held for a fixed number of clock cycles before it releases. A request that arrives under lockout is discarded. A cycle that is running when lockout asserts is abandoned. Cycle length and hold-off length are parameters counted in clock cycles, and a read port exposes the array contents.

Top module: `prog_engine`

## Requirements
- R1: A write request (`reqOp` = 0) with start address A and last index L (0 to 15) stores byte k of `reqData` (bits 8k+7 down to 8k) at address {A[6:4], (A[3:0]+k) mod 16} for k = 0..L, so the address wraps inside the 16-byte page. Every other location keeps its value.
- R2: An erase request (`reqOp` = 1) sets the location at `reqAddr` to 8'hFF and leaves every other location unchanged.
- R3: An erase-all request (`reqOp` = 2) sets all 128 locations to 8'hFF.
- R4: A write-all request (`reqOp` = 3) stores `reqData[7:0]` in all 128 locations, whatever they held before.
- R5: `busy` rises in the cycle after a request is accepted. It stays high for CYCLE_LEN cycles for a write or an erase, and for 128*CYCLE_LEN cycles for an array-wide request. The array shows the new contents from the cycle in which `busy` falls.
- R6: A request that arrives while `busy` is high is ignored and leaves the array unchanged.
- R7: `lockout` is high in the same cycle in which `supplyOk` is low, and it is high out of reset.
- R8: After `supplyOk` goes high, `lockout` stays high for exactly HOLDOFF rising clock edges and then falls. If the supply drops again inside that window, the window starts over.
- R9: A request that arrives while `lockout` is high is discarded: `busy` stays low and the array is unchanged.
- R10: If `lockout` asserts during a cycle, `busy` falls at the next edge. A write or erase in progress commits nothing. An array-wide request keeps the locations it has already finished, which are those from address 0 upward, one every CYCLE_LEN cycles.
- R11: After reset every location reads 8'hFF and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| supplyOk | input | 1 | Comparator output, high when the supply is above the trip level |
| reqValid | input | 1 | One-cycle pulse that hands over a completed request |
| reqOp | input | 2 | Request kind: 0 write, 1 erase, 2 erase-all, 3 write-all |
| reqAddr | input | 7 | Start address, or the location to erase |
| reqLastIdx | input | 4 | Index of the last byte in a write (number of bytes minus one) |
| reqData | input | 128 | Page buffer, byte k in bits 8k+7:8k |
| rdAddr | input | 7 | Read port address |
| rdData | output | 8 | Contents of the location at `rdAddr` |
| busy | output | 1 | High while a programming cycle runs |
| lockout | output | 1 | High while programming is blocked by the supply monitor |

## Verification
The bench sends page writes that cross the top of the page. A design that carried the offset into the page-number bits would corrupt the next page. It counts `busy` cycles edge by edge for both single and array-wide requests, which exposes an off-by-one cycle timer or a wrong sweep length. It counts the lockout hold-off to the exact edge, including a supply dip during the window that must restart the count. It drops the supply partway through a page write and partway through a fill. A design that committed the pending page anyway, or that lost the locations it had already filled, shows a mismatch against the bench's shadow array.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    OP_WRITE     = 2'd0,
    OP_ERASE     = 2'd1,
    OP_ERASE_ALL = 2'd2,
    OP_WRITE_ALL = 2'd3
  } opKind_t;

  typedef struct packed {
    logic       capture;
    logic       commitPage;
    logic       fillLoc;
    logic       fillOnes;
    logic [6:0] fillIdx;
  } strobe_t;
endpackage

// File: rtl/pe_lockout.sv
module pe_lockout #(
  parameter int HOLDOFF = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  output logic lockout
);
  localparam int HW = $clog2(HOLDOFF + 1);

  logic [HW-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       holdCnt <= HW'(HOLDOFF);
    else if (!supplyOk)              holdCnt <= HW'(HOLDOFF);
    else if (holdCnt != '0)          holdCnt <= holdCnt - 1'b1;
  end

  assign lockout = !supplyOk || (holdCnt != '0);

  p_recover_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(supplyOk) |-> lockout);
  p_release_after_good_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockout) |-> (supplyOk && $past(supplyOk)));
endmodule

// File: rtl/pe_ctrl.sv
module pe_ctrl
  import pe_pkg::*;
#(
  parameter int CYCLE_LEN = 16,
  parameter int DEPTH     = 128
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  opKind_t reqOp,
  input  logic    lockout,
  output logic    busy,
  output strobe_t strobe
);
  localparam int TW = $clog2(CYCLE_LEN + 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t        state;
  opKind_t       opReg;
  logic [TW-1:0] timer;
  logic [6:0]    idx;
  logic          accept, tick, arrayOp;

  assign accept  = (state == ST_IDLE) && reqValid && !lockout;
  assign tick    = (state == ST_RUN) && !lockout && (timer == '0);
  assign arrayOp = (opReg == OP_ERASE_ALL) || (opReg == OP_WRITE_ALL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opReg <= OP_WRITE;
      timer <= '0;
      idx   <= '0;
    end else if (accept) begin
      state <= ST_RUN;
      opReg <= reqOp;
      timer <= TW'(CYCLE_LEN - 1);
      idx   <= '0;
    end else if (state == ST_RUN) begin
      if (lockout) begin
        state <= ST_IDLE;
      end else if (timer != '0) begin
        timer <= timer - 1'b1;
      end else if (!arrayOp || idx == 7'(DEPTH - 1)) begin
        state <= ST_IDLE;
      end else begin
        idx   <= idx + 1'b1;
        timer <= TW'(CYCLE_LEN - 1);
      end
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.capture    = accept;
    strobe.commitPage = tick && !arrayOp;
    strobe.fillLoc    = tick && arrayOp;
    strobe.fillOnes   = (opReg == OP_ERASE_ALL);
    strobe.fillIdx    = idx;
  end

  assign busy = (state == ST_RUN);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && lockout) |=> !busy);
  p_drop_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && lockout) |=> !busy);
  p_start_after_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));
  p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lockout && timer != '0) |=> busy);
  p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.commitPage, strobe.fillLoc, strobe.capture}));
endmodule

// File: rtl/pe_datapath.sv
module pe_datapath
  import pe_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strobe,
  input  opKind_t                      reqOp,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [PAGE_W-1:0]            reqLastIdx,
  input  logic [(1<<PAGE_W)*DATA_W-1:0] reqData,
  input  logic [ADDR_W-1:0]            rdAddr,
  output logic [DATA_W-1:0]            rdData
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PAGE_LEN = 1 << PAGE_W;

  logic [DATA_W-1:0]            mem [DEPTH];
  logic [ADDR_W-1:0]            bufAddr;
  logic [PAGE_W-1:0]            bufLast;
  logic [PAGE_LEN*DATA_W-1:0]   bufData;

  function automatic logic [ADDR_W-1:0] pageSlot(input int k);
    logic [PAGE_W-1:0] off;
    off = bufAddr[PAGE_W-1:0] + PAGE_W'(k);
    return {bufAddr[ADDR_W-1:PAGE_W], off};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufAddr <= '0;
      bufLast <= '0;
      bufData <= '0;
    end else if (strobe.capture) begin
      bufAddr <= reqAddr;
      bufLast <= (reqOp == OP_ERASE) ? '0 : reqLastIdx;
      bufData <= (reqOp == OP_ERASE) ? '1 : reqData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strobe.commitPage) begin
      for (int k = 0; k < PAGE_LEN; k++)
        if (PAGE_W'(k) <= bufLast) mem[pageSlot(k)] <= bufData[k*DATA_W +: DATA_W];
    end else if (strobe.fillLoc) begin
      mem[strobe.fillIdx[ADDR_W-1:0]] <= strobe.fillOnes ? '1 : bufData[DATA_W-1:0];
    end
  end

  assign rdData = mem[rdAddr];

  p_erase_all_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillLoc && strobe.fillOnes) |=> (mem[$past(strobe.fillIdx[ADDR_W-1:0])] == '1));
  p_fill_value_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillLoc && !strobe.fillOnes) |=>
      (mem[$past(strobe.fillIdx[ADDR_W-1:0])] == $past(bufData[DATA_W-1:0])));
  p_first_byte_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitPage |=> (mem[$past(bufAddr)] == $past(bufData[DATA_W-1:0])));
endmodule

// File: rtl/prog_engine.sv
module prog_engine
  import pe_pkg::*;
#(
  parameter int CYCLE_LEN = 16,
  parameter int HOLDOFF   = 1000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         supplyOk,
  input  logic         reqValid,
  input  logic [1:0]   reqOp,
  input  logic [6:0]   reqAddr,
  input  logic [3:0]   reqLastIdx,
  input  logic [127:0] reqData,
  input  logic [6:0]   rdAddr,
  output logic [7:0]   rdData,
  output logic         busy,
  output logic         lockout
);
  strobe_t strobe;
  opKind_t opKind;

  assign opKind = opKind_t'(reqOp);

  pe_lockout #(.HOLDOFF(HOLDOFF)) lock_i (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .lockout(lockout)
  );

  pe_ctrl #(.CYCLE_LEN(CYCLE_LEN), .DEPTH(128)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(opKind),
    .lockout(lockout), .busy(busy), .strobe(strobe)
  );

  pe_datapath #(.ADDR_W(7), .DATA_W(8), .PAGE_W(4)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqOp(opKind),
    .reqAddr(reqAddr), .reqLastIdx(reqLastIdx), .reqData(reqData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  p_reset_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !busy);
  p_low_supply_r7: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |-> lockout);
endmodule

// File: tb/prog_engine_tb_top.sv
module prog_engine_tb_top;
  localparam int CL = 4;
  localparam int HO = 20;

  logic         clk = 0;
  logic         rstN = 0;
  logic         supplyOk = 0;
  logic         reqValid = 0;
  logic [1:0]   reqOp = 0;
  logic [6:0]   reqAddr = 0;
  logic [3:0]   reqLastIdx = 0;
  logic [127:0] reqData = 0;
  logic [6:0]   rdAddr = 0;
  logic [7:0]   rdData;
  logic         busy, lockout;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [128];

  always #2 clk = ~clk;

  prog_engine #(.CYCLE_LEN(CL), .HOLDOFF(HO)) dut_i (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .reqValid(reqValid),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqLastIdx(reqLastIdx), .reqData(reqData),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .lockout(lockout)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void modelApply(input logic [1:0] op, input logic [6:0] a,
                                     input logic [3:0] last, input logic [127:0] d);
    case (op)
      2'd0: for (int k = 0; k <= int'(last); k++)
              model[{a[6:4], 4'(a[3:0] + 4'(k))}] = d[k*8 +: 8];
      2'd1: model[a] = 8'hFF;
      2'd2: for (int i = 0; i < 128; i++) model[i] = 8'hFF;
      default: for (int i = 0; i < 128; i++) model[i] = d[7:0];
    endcase
  endfunction

  task automatic compareArray(input string req);
    int bad = 0;
    logic [7:0] badAct = 0, badExp = 0;
    for (int i = 0; i < 128; i++) begin
      rdAddr = 7'(i);
      #0.5;
      if (rdData !== model[i] && bad == 0) begin
        badAct = rdData; badExp = model[i];
        $display("  mismatch at address %0d", i);
      end
      if (rdData !== model[i]) bad++;
    end
    check(req, {24'd0, badAct}, {24'd0, badExp});
  endtask

  task automatic issue(input logic [1:0] op, input logic [6:0] a,
                       input logic [3:0] last, input logic [127:0] d);
    @(negedge clk);
    reqOp = op; reqAddr = a; reqLastIdx = last; reqData = d; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic waitRelease();
    while (lockout) @(negedge clk);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    int n;
    logic [127:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 128; i++) model[i] = 8'hFF;
    #7 rstN = 1;
    @(negedge clk);
    check("R11 busy after reset", busy, 0);
    check("R7 lockout after reset", lockout, 1);
    compareArray("R11 array erased after reset");

    // R9: request under lockout
    issue(2'd0, 7'h05, 4'd0, 128'hAB);
    repeat (CL + 2) @(negedge clk);
    check("R9 busy stays low under lockout", busy, 0);
    compareArray("R9 array unchanged under lockout");

    // R8: exact hold-off
    supplyOk = 1;
    repeat (HO - 1) @(negedge clk);
    check("R8 lockout held before hold-off ends", lockout, 1);
    @(negedge clk);
    check("R8 lockout released after hold-off", lockout, 0);

    // R1 page write with wrap
    d = rnd128();
    issue(2'd0, 7'h1D, 4'd5, d);
    check("R5 busy rises after accept", busy, 1);
    busyLen(n);
    check("R5 single cycle length", n, CL);
    modelApply(2'd0, 7'h1D, 4'd5, d);
    compareArray("R1 page write wraps within page");

    // R6 request while busy
    d = rnd128();
    issue(2'd0, 7'h40, 4'd15, d);
    modelApply(2'd0, 7'h40, 4'd15, d);
    @(negedge clk);
    reqOp = 2'd1; reqAddr = 7'h41; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    while (busy) @(negedge clk);
    repeat (CL + 2) @(negedge clk);
    check("R6 no second cycle started", busy, 0);
    compareArray("R6 busy-time request ignored");

    // R2 erase
    issue(2'd1, 7'h42, 4'd7, 128'h0);
    busyLen(n);
    modelApply(2'd1, 7'h42, 4'd7, 128'h0);
    compareArray("R2 single erase");

    // random writes and erases
    for (int t = 0; t < 24; t++) begin
      logic [1:0] op = ($urandom % 4 == 0) ? 2'd1 : 2'd0;
      logic [6:0] a = 7'($urandom);
      logic [3:0] l = 4'($urandom);
      d = rnd128();
      issue(op, a, l, d);
      busyLen(n);
      modelApply(op, a, l, d);
    end
    compareArray("R1 R2 random writes and erases");

    // R4 write-all
    d = rnd128();
    issue(2'd3, 7'h00, 4'd0, d);
    busyLen(n);
    check("R5 array-wide cycle length", n, 128 * CL);
    modelApply(2'd3, 7'h00, 4'd0, d);
    compareArray("R4 write-all");

    // R3 erase-all
    issue(2'd2, 7'h00, 4'd0, 128'h0);
    busyLen(n);
    modelApply(2'd2, 7'h00, 4'd0, 128'h0);
    compareArray("R3 erase-all");

    // R10 abort page write
    issue(2'd0, 7'h10, 4'd3, rnd128());
    @(negedge clk);
    supplyOk = 0;
    #0.5;
    check("R7 lockout immediate on supply drop", lockout, 1);
    @(negedge clk);
    check("R10 busy cleared after abort", busy, 0);
    compareArray("R10 aborted write commits nothing");

    // R8 restart on dip during hold-off
    @(negedge clk); supplyOk = 1;
    repeat (HO / 2) @(negedge clk);
    supplyOk = 0;
    @(negedge clk); supplyOk = 1;
    repeat (HO - 1) @(negedge clk);
    check("R8 hold-off restarted by dip", lockout, 1);
    @(negedge clk);
    check("R8 release after restarted hold-off", lockout, 0);

    // R10 abort array fill midway
    issue(2'd3, 7'h00, 4'd0, 128'h5A);
    repeat (10 * CL) @(negedge clk);
    supplyOk = 0;
    @(negedge clk);
    check("R10 fill aborted", busy, 0);
    for (int i = 0; i < 10; i++) model[i] = 8'h5A;
    compareArray("R10 fill keeps finished locations");
    supplyOk = 1;
    waitRelease();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule